// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 active-low interrupt requests and presents them to a processor as one interrupt line plus a vector that names the most urgent source. Software sees four 32-bit words on a single-cycle register port: a pending word, an enable (mask) word, a sense word that turns selected sources into falling-edge latches, and a read-only vector word. Every word numbers its sources from the top, so source n occupies bit 31-n.

Each raw request first passes through a two-stage synchronizer. A source in level mode shows its live request level in the pending word. A source in edge mode sets its pending bit on a high-to-low transition, and the bit stays set until software writes a one to it. Only even-numbered sources can be put in edge mode. Among the pending sources that are enabled, the lowest-numbered one wins, and its number appears in the top six bits of the vector word. Code 15 means that nothing is pending.

Register selection uses a two-bit word index, decoded into the named selects PEND_SEL (index 0), MASK_SEL (index 1), SENSE_SEL (index 2) and VEC_SEL (index 3). These correspond to byte offsets 0x0, 0x4, 0x8 and 0xC. The block contains no sequential control state beyond the registers themselves.

Top module: `vec_intc`

## Requirements
- R1: Source n is held at bit 31-n of the pending, mask and sense words, so source 0 is bit 31 and source 31 is bit 0.
- R2: A mask bit of 1 enables its source and a 0 disables it. The mask word reads back exactly the 32-bit value last written.
- R3: A source whose sense bit is 0 shows its synchronized request in the pending word: bit = 1 while `irq_req_n` is low. A change at the input appears in the pending word after the third rising clock edge, and writes to a level-mode pending bit have no effect.
- R4: A source whose sense bit is 1 sets its pending bit on a 1-to-0 transition of its request. The bit then stays set, even after the request returns high, until a 1 is written to it. Writing 0 leaves it set. A request that is held low after being cleared does not set it again.
- R5: Sense bits can be written only for even-numbered sources, which are the odd bit positions (0xAAAAAAAA). Sense bits for odd-numbered sources always read 0.
- R6: Vector word bits 31:26 hold the number of the lowest-numbered source that is both pending and enabled. Bits 25:0 read 0.
- R7: When no source is both pending and enabled, vector bits 31:26 read 15 (word 0x3C000000).
- R8: `irq_out` is 1 exactly when the AND of the pending and mask words was nonzero on the previous cycle, so it lags that state by one clock.
- R9: Word index 0/1/2/3 selects pending/mask/sense/vector. A write to the vector word changes no state.
- R10: After reset the pending, mask and sense words read 0, the vector word reads 0x3C000000 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 2 | Word index of the register being accessed (byte offset / 4) |
| reg_we | input | 1 | Write strobe, takes effect at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx`, combinational |
| irq_req_n | input | 32 | Raw active-low interrupt requests, source n on bit 31-n |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
An input change reaches the pending and vector words on the third rising edge and `irq_out` on the fourth. A register write is visible on the read port right after the edge that takes it, and `irq_out` follows a write-one clear one edge later. The bench drives inputs on falling edges, counts falling edges to land on exactly those cycles, and samples the combinational read port 1 ns after setting the index. The table cases wait long enough for everything to settle. The directed latency cases check the cycle just before each result is due and the cycle in which it arrives.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        PEND_SEL  = 2'd0,
        MASK_SEL  = 2'd1,
        SENSE_SEL = 2'd2,
        VEC_SEL   = 2'd3
    } reg_sel_e;

    // bit positions whose source number (width-1-bit) is even
    function automatic logic [31:0] edge_capable_bits(input int width);
        logic [31:0] m;
        m = '0;
        for (int b = 0; b < width; b++) begin
            if (((width - 1 - b) % 2) == 0) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '1;
                end else if (s == 0) begin
                    stage_q[s] <= d_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/vic_pend.sv
module vic_pend #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_n_s,
    input  logic            pend_we,
    input  logic            sense_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] pend_q,
    output logic [NSRC-1:0] sense_q
);
    import vic_pkg::*;

    localparam logic [31:0] EDGE_MASK = edge_capable_bits(NSRC);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^(wdata & ~EDGE_MASK[NSRC-1:0]);

    generate
        for (genvar b = 0; b < NSRC; b++) begin : g_bit
            if (EDGE_MASK[b]) begin : g_edge
                logic sense_b, pend_b, prev_b, fall_b;

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        sense_b <= 1'b0;
                    else if (sense_we) sense_b <= wdata[b];
                end

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) prev_b <= 1'b1;
                    else        prev_b <= req_n_s[b];
                end

                assign fall_b = prev_b & ~req_n_s[b];

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        pend_b <= 1'b0;
                    end else if (sense_b) begin
                        if (fall_b)                      pend_b <= 1'b1;
                        else if (pend_we && wdata[b])    pend_b <= 1'b0;
                    end else begin
                        pend_b <= ~req_n_s[b];
                    end
                end

                assign pend_q[b]  = pend_b;
                assign sense_q[b] = sense_b;

                // R4: a latched edge bit survives until cleared by a written one
                assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (sense_b && pend_b && !(pend_we && wdata[b]))
                    |=> (pend_b || !sense_b));
            end else begin : g_lvl
                logic pend_b;

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pend_b <= 1'b0;
                    else        pend_b <= ~req_n_s[b];
                end

                assign pend_q[b]  = pend_b;
                assign sense_q[b] = 1'b0;

                // R3: a level-only source mirrors the synchronized request a cycle later
                assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> (pend_b == !$past(req_n_s[b])));
            end
        end
    endgenerate

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NSRC      = 32,
    parameter int CODE_W    = 6,
    parameter int IDLE_CODE = 15
) (
    input  logic [NSRC-1:0]   req,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        code = CODE_W'(IDLE_CODE);
        // walk from highest source number down so the lowest number wins
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (req[NSRC-1-n]) code = CODE_W'(n);
        end
    end

endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
    parameter int NSRC      = 32,
    parameter int SYNC_LEN  = 2,
    parameter int CODE_W    = 6,
    parameter int IDLE_CODE = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      reg_idx,
    input  logic            reg_we,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    input  logic [NSRC-1:0] irq_req_n,
    output logic            irq_out
);
    import vic_pkg::*;

    localparam int VEC_PAD = NSRC - CODE_W;

    reg_sel_e          sel;
    logic [NSRC-1:0]   req_n_s;
    logic [NSRC-1:0]   pend_q, sense_q, mask_q, en_w;
    logic [CODE_W-1:0] code;
    logic              irq_q;

    assign sel = reg_sel_e'(reg_idx);

    vic_sync #(.WIDTH(NSRC), .STAGES(SYNC_LEN)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_req_n),
        .d_out (req_n_s)
    );

    vic_pend #(.NSRC(NSRC)) i_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_n_s  (req_n_s),
        .pend_we  (reg_we && sel == PEND_SEL),
        .sense_we (reg_we && sel == SENSE_SEL),
        .wdata    (reg_wdata),
        .pend_q   (pend_q),
        .sense_q  (sense_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         mask_q <= '0;
        else if (reg_we && sel == MASK_SEL) mask_q <= reg_wdata;
    end

    assign en_w = pend_q & mask_q;

    vic_prio #(.NSRC(NSRC), .CODE_W(CODE_W), .IDLE_CODE(IDLE_CODE)) i_prio (
        .req  (en_w),
        .code (code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |en_w;
    end

    assign irq_out = irq_q;

    always_comb begin
        unique case (sel)
            PEND_SEL:  reg_rdata = pend_q;
            MASK_SEL:  reg_rdata = mask_q;
            SENSE_SEL: reg_rdata = sense_q;
            VEC_SEL:   reg_rdata = {code, {VEC_PAD{1'b0}}};
            default:   reg_rdata = '0;
        endcase
    end

    // R8: the request line lags the enabled-pending state by one clock
    assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|en_w)));

    // R6: the reported source is enabled and pending, with none of lower number
    assert_vec_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_w) |-> (en_w[NSRC-1-int'(code)] &&
                     ((en_w & ~({NSRC{1'b1}} >> code)) == '0)));

    // R7: idle code whenever nothing enabled is pending
    assert_vec_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w == '0) |-> (code == CODE_W'(IDLE_CODE)));

endmodule

// File: tb/test_vec_intc.sv
`timescale 1ns/1ps
module test_vec_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_req_n = '1;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vec_intc i_vec_intc (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_idx   (reg_idx),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req_n (irq_req_n),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic [31:0] req_n;
        logic [31:0] mask;
        logic [31:0] pend;
        logic [5:0]  code;
        logic        irq;
    } case_t;

    localparam int NCASE = 8;
    localparam case_t CASES [NCASE] = '{
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 6'd15, 1'b0},
        '{32'hEFFF_FFFF, 32'hFFFF_FFFF, 32'h1000_0000, 6'd3,  1'b1},
        '{32'hFBFF_F7FF, 32'hFFFF_FFFF, 32'h0400_0800, 6'd5,  1'b1},
        '{32'hFBFF_F7FF, 32'hFBFF_FFFF, 32'h0400_0800, 6'd20, 1'b1},
        '{32'h7FFF_FFFE, 32'hFFFF_FFFF, 32'h8000_0001, 6'd0,  1'b1},
        '{32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_0001, 6'd31, 1'b1},
        '{32'hFEFF_FFFF, 32'h0000_0000, 32'h0100_0000, 6'd15, 1'b0},
        '{32'hFFFE_7FFF, 32'h0000_8000, 32'h0001_8000, 6'd16, 1'b1}
    };

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [1:0] idx, input logic [31:0] exp, input string req);
        reg_idx = idx;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_idx = idx; reg_wdata = data; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd_chk(2'd0, 32'h0, "R10 pending");
        rd_chk(2'd1, 32'h0, "R10 mask");
        rd_chk(2'd2, 32'h0, "R10 sense");
        rd_chk(2'd3, 32'h3C00_0000, "R10 vector");
        chk("R10 irq", {31'd0, irq_out}, 32'd0);

        // R1 R6 R7 R8: table of level-mode patterns
        for (int k = 0; k < NCASE; k++) begin
            wr(2'd1, CASES[k].mask);
            irq_req_n = CASES[k].req_n;
            settle();
            rd_chk(2'd0, CASES[k].pend, $sformatf("R1 case %0d pending", k));
            rd_chk(2'd3, {CASES[k].code, 26'd0}, $sformatf("R6 R7 case %0d vector", k));
            chk($sformatf("R8 case %0d irq", k), {31'd0, irq_out}, {31'd0, CASES[k].irq});
        end
        irq_req_n = '1;
        settle();

        // R2: mask readback
        wr(2'd1, 32'h1234_5678);
        rd_chk(2'd1, 32'h1234_5678, "R2 mask readback");

        // R5: only even sources accept a sense bit
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk(2'd2, 32'hAAAA_AAAA, "R5 sense writable bits");
        wr(2'd2, 32'h4000_0000);
        rd_chk(2'd2, 32'h0000_0000, "R5 odd source sense ignored");

        // R9: vector write has no effect
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk(2'd3, 32'h3C00_0000, "R9 vector write ignored");
        rd_chk(2'd1, 32'h1234_5678, "R9 mask untouched by vector write");
        rd_chk(2'd2, 32'h0000_0000, "R9 sense untouched by vector write");

        // R3 R8: latency of level source 9 (bit 22)
        wr(2'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        irq_req_n = 32'hFFBF_FFFF;
        repeat (2) @(negedge clk);
        rd_chk(2'd0, 32'h0, "R3 pending not yet after two edges");
        @(negedge clk);
        rd_chk(2'd0, 32'h0040_0000, "R3 pending after third edge");
        chk("R8 irq not yet", {31'd0, irq_out}, 32'd0);
        rd_chk(2'd3, 32'h2400_0000, "R6 vector source 9");
        @(negedge clk);
        chk("R8 irq after fourth edge", {31'd0, irq_out}, 32'd1);
        irq_req_n = '1;
        repeat (3) @(negedge clk);
        rd_chk(2'd0, 32'h0, "R3 pending follows release");
        chk("R8 irq still high", {31'd0, irq_out}, 32'd1);
        @(negedge clk);
        chk("R8 irq falls", {31'd0, irq_out}, 32'd0);

        // R3: write-one on a held level source has no effect
        irq_req_n = 32'hF7FF_FFFF;
        settle();
        wr(2'd0, 32'h0800_0000);
        rd_chk(2'd0, 32'h0800_0000, "R3 level bit ignores write-one");
        irq_req_n = '1;
        settle();

        // R4: edge mode on source 2 (bit 29)
        wr(2'd2, 32'h2000_0000);
        rd_chk(2'd2, 32'h2000_0000, "R1 R4 sense source 2");
        @(negedge clk);
        irq_req_n = 32'hDFFF_FFFF;
        repeat (4) @(negedge clk);
        irq_req_n = '1;
        settle();
        rd_chk(2'd0, 32'h2000_0000, "R4 edge latched after release");
        rd_chk(2'd3, 32'h0800_0000, "R6 vector source 2");
        wr(2'd0, 32'h0000_0000);
        rd_chk(2'd0, 32'h2000_0000, "R4 write zero keeps bit");
        chk("R8 irq with latched edge", {31'd0, irq_out}, 32'd1);
        wr(2'd0, 32'h2000_0000);
        rd_chk(2'd0, 32'h0, "R4 write one clears");
        rd_chk(2'd3, 32'h3C00_0000, "R7 vector idle after clear");
        chk("R8 irq one cycle after clear", {31'd0, irq_out}, 32'd1);
        @(negedge clk);
        chk("R8 irq drops", {31'd0, irq_out}, 32'd0);

        // R4: held low after clear does not re-latch
        irq_req_n = 32'hDFFF_FFFF;
        settle();
        rd_chk(2'd0, 32'h2000_0000, "R4 new edge latched");
        wr(2'd0, 32'h2000_0000);
        settle();
        rd_chk(2'd0, 32'h0, "R4 held low does not re-latch");
        irq_req_n = '1;
        settle();

        done = 1'b1;
        report();
        $finish;
    end

endmodule